// File: doc/BRIEF.md
# Scan-Rate, Thermal Override and Self-Test Sequencer

This block sets how often a panel's drive electronics rescan the screen. Two static selection pins pick one of three scan rates: fast (about 325 Hz, full brightness), middle (about 240 Hz) or slow (about 180 Hz). For each rate the block also presents the matching frame-tick divider value for the scan timer. When both selection pins are high, which is also their state when left open, the block enables a built-in self-test. The self-test runs at the fast rate and steps a pattern index through four fixed test images.

A digital board-temperature code is compared against two thresholds that software supplies. When the code rises above the upper threshold, a single sticky flag forces the slow rate. This lowers drive power but never blanks the display, and the self-test state and the pattern index are left as they are. The flag is released only when the code falls below the lower threshold, or by a reset.

The self-test shows four patterns in a fixed order. Each pattern is held for a parameterized number of clock cycles, which is about four seconds in silicon. The full sequence runs a parameterized number of times (three by default) and then stays on the final all-yellow image. Every control pin is a plain level; there is no streaming data path.

Top module: `scan_rate_ctl`

## Requirements
- R1: While `rst_n` is low and at its release, the thermal flag is clear and the pattern sequencer is at its start, so `pattern_o` is 0.
- R2: With `dim_a_i`=0 and `dim_b_i`=0 and no thermal override, `rate_o` is 0 (fast) and `scan_div_o` equals `DIV_FAST`.
- R3: `dim_a_i`=1 with `dim_b_i`=0 gives `rate_o`=1 (middle, `DIV_MID`). `dim_a_i`=0 with `dim_b_i`=1 gives `rate_o`=2 (slow, `DIV_SLOW`). Neither combination enables self-test.
- R4: `dim_a_i`=1 with `dim_b_i`=1 drives `selftest_o` high in the same cycle, and with no thermal override `rate_o` is 0.
- R5: A clock edge that samples `temp_code_i` > `trip_hi_i` sets the thermal flag. From the next cycle on, `rate_o` is 2 and `scan_div_o` is `DIV_SLOW` whatever the selection pins are; `selftest_o` and `pattern_o` are unaffected.
- R6: Once set, the flag holds while `trip_lo_i` <= `temp_code_i` <= `trip_hi_i`. It clears at an edge that samples `temp_code_i` < `trip_lo_i`, and pin-based selection then resumes in the next cycle.
- R7: A reset clears a set thermal flag even if the temperature stays inside the hysteresis band.
- R8: During self-test, `pattern_o` steps 0 (diagonal lines with a perimeter box), 1 (all red), 2 (all green), 3 (all yellow). Each value lasts `HOLD_CYCLES` clock edges counted from the first edge at which self-test is selected.
- R9: After `PASSES` complete sequences, `pattern_o` stays at 3 for as long as self-test remains selected.
- R10: Outside self-test, `pattern_o` is 0 and the sequencer is held at its start, so re-entering self-test restarts the sequence from pattern 0 and pass 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, power-on |
| dim_a_i | input | 1 | Rate select pin A |
| dim_b_i | input | 1 | Rate select pin B |
| temp_code_i | input | TEMP_W | Board temperature code |
| trip_hi_i | input | TEMP_W | Over-temperature set threshold |
| trip_lo_i | input | TEMP_W | Over-temperature release threshold |
| rate_o | output | 2 | Scan rate code: 0 fast, 1 middle, 2 slow |
| scan_div_o | output | DIV_W | Frame-tick divider value for the chosen rate |
| selftest_o | output | 1 | Self-test enable |
| pattern_o | output | 2 | Self-test pattern index |

## Verification
The bench builds the block with `HOLD_CYCLES` = 6 and the default `PASSES` = 3. At these values one pattern lasts six edges, and the final hold starts 66 edges after entry, so a single directed run covers every step, the pass wrap and the terminal hold. The thresholds are fixed at 100 and 92 on an 8-bit code. Random temperatures in the range 80 to 115 therefore cross both edges of the hysteresis band often, including while self-test is running.

// File: rtl/scan_ctl_pkg.sv
package scan_ctl_pkg;
  typedef enum logic [1:0] {
    RATE_FAST = 2'd0,
    RATE_MID  = 2'd1,
    RATE_SLOW = 2'd2
  } rate_e;

  typedef enum logic [1:0] {
    PAT_DIAG   = 2'd0,
    PAT_RED    = 2'd1,
    PAT_GREEN  = 2'd2,
    PAT_YELLOW = 2'd3
  } pattern_e;
endpackage

// File: rtl/thermal_latch.sv
module thermal_latch #(
  parameter int TEMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code_i,
  input  logic [TEMP_W-1:0] trip_hi_i,
  input  logic [TEMP_W-1:0] trip_lo_i,
  output logic              hot_o
);
  logic hot_q;

  // Set above the upper threshold, clear below the lower, hold in between.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q <= 1'b0;
    end else if (temp_code_i > trip_hi_i) begin
      hot_q <= 1'b1;
    end else if (temp_code_i < trip_lo_i) begin
      hot_q <= 1'b0;
    end
  end

  assign hot_o = hot_q;
endmodule

// File: rtl/rate_pick.sv
module rate_pick
  import scan_ctl_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int DIV_FAST = 30769,
  parameter int DIV_MID  = 41667,
  parameter int DIV_SLOW = 55556
) (
  input  logic             dim_a_i,
  input  logic             dim_b_i,
  input  logic             hot_i,
  output rate_e            rate_o,
  output logic [DIV_W-1:0] div_o,
  output logic             selftest_o
);
  rate_e pin_rate;

  always_comb begin
    selftest_o = dim_a_i & dim_b_i;
    unique case ({dim_b_i, dim_a_i})
      2'b00:   pin_rate = RATE_FAST;
      2'b01:   pin_rate = RATE_MID;
      2'b10:   pin_rate = RATE_SLOW;
      default: pin_rate = RATE_FAST;  // self-test runs at the fast rate
    endcase
    rate_o = hot_i ? RATE_SLOW : pin_rate;
    unique case (rate_o)
      RATE_MID:  div_o = DIV_W'(DIV_MID);
      RATE_SLOW: div_o = DIV_W'(DIV_SLOW);
      default:   div_o = DIV_W'(DIV_FAST);
    endcase
  end
endmodule

// File: rtl/pattern_seq.sv
module pattern_seq
  import scan_ctl_pkg::*;
#(
  parameter int HOLD_CYCLES = 40_000_000,
  parameter int PASSES      = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run_i,
  output pattern_e pattern_o
);
  localparam int HOLD_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam int PASS_W = $clog2(PASSES + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYCLES - 1);
  localparam logic [PASS_W-1:0] PASS_LAST = PASS_W'(PASSES - 1);
  localparam logic [PASS_W-1:0] PASS_DONE = PASS_W'(PASSES);

  logic [HOLD_W-1:0] tick_q;
  logic [PASS_W-1:0] pass_q;
  pattern_e          pat_q;
  logic              done;

  assign done = (pass_q == PASS_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      pass_q <= '0;
      pat_q  <= PAT_DIAG;
    end else if (!run_i) begin
      tick_q <= '0;
      pass_q <= '0;
      pat_q  <= PAT_DIAG;
    end else if (!done) begin
      if (tick_q == HOLD_LAST) begin
        tick_q <= '0;
        if (pat_q == PAT_YELLOW) begin
          if (pass_q == PASS_LAST) begin
            pass_q <= PASS_DONE;        // terminal: hold on yellow
          end else begin
            pass_q <= pass_q + 1'b1;
            pat_q  <= PAT_DIAG;
          end
        end else begin
          pat_q <= pattern_e'(pat_q + 2'd1);
        end
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign pattern_o = run_i ? pat_q : PAT_DIAG;
endmodule

// File: rtl/scan_rate_ctl.sv
module scan_rate_ctl
  import scan_ctl_pkg::*;
#(
  parameter int TEMP_W      = 8,
  parameter int DIV_W       = 16,
  parameter int DIV_FAST    = 30769,
  parameter int DIV_MID     = 41667,
  parameter int DIV_SLOW    = 55556,
  parameter int HOLD_CYCLES = 40_000_000,
  parameter int PASSES      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dim_a_i,
  input  logic              dim_b_i,
  input  logic [TEMP_W-1:0] temp_code_i,
  input  logic [TEMP_W-1:0] trip_hi_i,
  input  logic [TEMP_W-1:0] trip_lo_i,
  output logic [1:0]        rate_o,
  output logic [DIV_W-1:0]  scan_div_o,
  output logic              selftest_o,
  output logic [1:0]        pattern_o
);
  logic     hot;
  rate_e    rate;
  pattern_e pat;

  thermal_latch #(.TEMP_W(TEMP_W)) i_thermal (
    .clk(clk), .rst_n(rst_n), .temp_code_i(temp_code_i),
    .trip_hi_i(trip_hi_i), .trip_lo_i(trip_lo_i), .hot_o(hot)
  );

  rate_pick #(
    .DIV_W(DIV_W), .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)
  ) i_rate (
    .dim_a_i(dim_a_i), .dim_b_i(dim_b_i), .hot_i(hot),
    .rate_o(rate), .div_o(scan_div_o), .selftest_o(selftest_o)
  );

  pattern_seq #(.HOLD_CYCLES(HOLD_CYCLES), .PASSES(PASSES)) i_pattern (
    .clk(clk), .rst_n(rst_n), .run_i(selftest_o), .pattern_o(pat)
  );

  assign rate_o    = rate;
  assign pattern_o = pat;
endmodule

// File: rtl/scan_ctl_chk.sv
module scan_ctl_chk #(
  parameter int TEMP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dim_a_i,
  input logic              dim_b_i,
  input logic [TEMP_W-1:0] temp_code_i,
  input logic [TEMP_W-1:0] trip_hi_i,
  input logic [TEMP_W-1:0] trip_lo_i,
  input logic [1:0]        rate_o,
  input logic              selftest_o,
  input logic [1:0]        pattern_o
);
  p_hot_forces_slow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code_i > trip_hi_i) |=> (rate_o == 2'd2));

  p_cool_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code_i < trip_lo_i) |=> (dim_a_i || dim_b_i || rate_o == 2'd0));

  p_selftest_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code_i < trip_lo_i) |=>
      (!(dim_a_i && dim_b_i) || (selftest_o && rate_o == 2'd0)));

  p_idle_pattern_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !selftest_o |-> (pattern_o == 2'd0));

  p_pattern_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (selftest_o && $past(selftest_o)) |->
      (pattern_o == $past(pattern_o) || pattern_o == $past(pattern_o) + 2'd1));
endmodule

bind scan_rate_ctl scan_ctl_chk #(.TEMP_W(TEMP_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .dim_a_i(dim_a_i), .dim_b_i(dim_b_i),
  .temp_code_i(temp_code_i), .trip_hi_i(trip_hi_i), .trip_lo_i(trip_lo_i),
  .rate_o(rate_o), .selftest_o(selftest_o), .pattern_o(pattern_o)
);

// File: tb/test_scan_rate_ctl.sv
module test_scan_rate_ctl;
  localparam int CLK_P    = 10;
  localparam int TEMP_W   = 8;
  localparam int DIV_W    = 16;
  localparam int D_FAST   = 30769;
  localparam int D_MID    = 41667;
  localparam int D_SLOW   = 55556;
  localparam int HOLD     = 6;
  localparam int PASSES   = 3;
  localparam int HI       = 100;
  localparam int LO       = 92;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dim_a = 1'b0, dim_b = 1'b0;
  logic [TEMP_W-1:0] temp = 8'd50;
  logic [TEMP_W-1:0] trip_hi = 8'(HI);
  logic [TEMP_W-1:0] trip_lo = 8'(LO);
  logic [1:0] rate;
  logic [DIV_W-1:0] div;
  logic selftest;
  logic [1:0] pattern;

  int checks = 0;
  int fails = 0;
  bit hot_m = 1'b0;
  int k_m = 0;

  always #(CLK_P/2) clk = ~clk;

  scan_rate_ctl #(
    .TEMP_W(TEMP_W), .DIV_W(DIV_W), .DIV_FAST(D_FAST), .DIV_MID(D_MID),
    .DIV_SLOW(D_SLOW), .HOLD_CYCLES(HOLD), .PASSES(PASSES)
  ) i_scan_rate_ctl (
    .clk(clk), .rst_n(rst_n), .dim_a_i(dim_a), .dim_b_i(dim_b),
    .temp_code_i(temp), .trip_hi_i(trip_hi), .trip_lo_i(trip_lo),
    .rate_o(rate), .scan_div_o(div), .selftest_o(selftest), .pattern_o(pattern)
  );

  function automatic int exp_rate(bit a, bit b, bit hot);
    if (hot) return 2;
    if (a && b) return 0;
    if (a) return 1;
    if (b) return 2;
    return 0;
  endfunction

  function automatic int exp_div(int r);
    return (r == 1) ? D_MID : (r == 2) ? D_SLOW : D_FAST;
  endfunction

  function automatic int exp_pat(int k);
    int s = k / HOLD;
    if (s >= 4 * PASSES - 1) return 3;
    return s % 4;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    int er = exp_rate(dim_a, dim_b, hot_m);
    check(tag, "rate", rate, er);
    check(tag, "divider", div, exp_div(er));
    check(tag, "selftest", selftest, int'(dim_a && dim_b));
    check(tag, "pattern", pattern, (dim_a && dim_b) ? exp_pat(k_m) : 0);
  endtask

  // Drive at negedge, let one edge pass, update model, sample after the edge.
  task automatic step(bit a, bit b, int t, string tag);
    @(negedge clk);
    dim_a = a; dim_b = b; temp = 8'(t);
    @(posedge clk);
    if (rst_n) begin
      if (t > HI) hot_m = 1'b1;
      else if (t < LO) hot_m = 1'b0;
      if (a && b) k_m++; else k_m = 0;
    end else begin
      hot_m = 1'b0; k_m = 0;
    end
    #1;
    check_all(tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    step(0, 0, 50, "R1");
    step(0, 0, 50, "R1");
    @(negedge clk); rst_n = 1'b1;
    #1 check_all("R1");
    // R2 / R3: pin selections
    step(0, 0, 50, "R2");
    step(1, 0, 50, "R3");
    step(0, 1, 50, "R3");
    step(0, 0, 50, "R2");
    // R5: over-temperature forces slow in every selection
    step(0, 0, 101, "R5");
    step(1, 0, 95, "R5");
    step(0, 0, 96, "R6");
    step(1, 1, 100, "R6");  // exactly at trip_hi: still hot, not newly set
    step(0, 0, 92, "R6");   // at trip_lo: held
    step(0, 0, 91, "R6");   // release
    step(0, 0, 95, "R6");
    step(1, 0, 95, "R6");
    // R7: reset clears a set flag inside the band
    step(0, 0, 110, "R7");
    step(0, 0, 95, "R7");
    @(negedge clk); rst_n = 1'b0;
    step(0, 0, 95, "R7");
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 95, "R7");
    // R4 / R8 / R9: full self-test run and terminal hold
    for (int i = 0; i < 4 * PASSES * HOLD + 20; i++)
      step(1, 1, 50, (i < 4 * PASSES * HOLD - HOLD) ? "R8" : "R9");
    // R5 during self-test: rate slow, patterns continue
    for (int i = 0; i < 8; i++) step(1, 1, 105, "R5");
    // R10: leave and re-enter self-test
    step(1, 0, 80, "R10");
    for (int i = 0; i < 2 * HOLD + 2; i++) step(1, 1, 80, "R10");
    step(0, 1, 80, "R10");
    step(1, 1, 80, "R10");
    // Random phase with sticky pins and temperatures around the band
    begin
      bit a = 1'b1, b = 1'b1;
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(0, 39) == 0) begin
          a = 1'($urandom); b = 1'($urandom);
        end
        step(a, b, $urandom_range(80, 115), "R6");
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule